// File: doc/BRIEF.md
# Transmit PHY Enable Sequencer

This block walks an external radio PHY through one transmission. A one-cycle start request, taken only while the block is idle, raises a transmit command line. After a programmable number of bit times it raises a PHY enable line. After a second programmable wait it pulls bytes from a transmit FIFO and shifts them out on a serial data line, least significant bit first, one bit per bit time. When the last bit has gone out, the data line returns to 0. The enable line drops after a third wait, and the command line drops after a fourth wait. That final drop ends the transmission.

Each of the four waits has its own delay input. Time is counted only on cycles where the bit-clock enable is high. A delay value of D makes the next step occur on the (D+1)-th bit-time tick after the previous step. The FIFO read port is show-ahead: the byte and its frame-end flag are valid while the FIFO is not empty, and `fifo_pop_o` removes them at the same clock edge.

Top module: `txphy_seq`

## Requirements
- R1: A `start_i` pulse while `busy_o` is 0 sets `tx_cmd_o` and `busy_o` to 1 at the next clock edge.
- R2: `phy_en_o` rises on the (`gap_cmd_en_i`+1)-th bit tick (clock edge with `bit_en_i`=1) after the edge at which `tx_cmd_o` rose.
- R3: The first data bit appears on `sdata_o` on the (`gap_en_data_i`+1)-th bit tick after `phy_en_o` rose. Each byte is taken from the FIFO with exactly one `fifo_pop_o` cycle, so a frame of N bytes pops N times. A pop occurs only on a bit tick while `phy_en_o` is 1.
- R4: Bits of each byte leave LSB-first, one per bit tick, with no gap between bytes. The byte whose `fifo_last_i` was 1 when it was popped is the final byte of the frame.
- R5: `sdata_o` is 0 whenever no data is being sent. That includes the bit tick right after the final bit and any time `phy_en_o` is 0.
- R6: `phy_en_o` falls on the (`gap_data_en_i`+1)-th bit tick after the tick on which the data line returned to idle.
- R7: `tx_cmd_o` falls on the (`gap_en_cmd_i`+1)-th bit tick after `phy_en_o` fell, and `busy_o` falls with it.
- R8: A `start_i` pulse while `busy_o` is 1 is ignored. The running sequence keeps its timing, and no new sequence follows it.
- R9: While and right after reset, `tx_cmd_o`, `phy_en_o`, `sdata_o`, `busy_o` and `fifo_pop_o` are all 0.
- R10: `phy_en_o` is 1 only while `tx_cmd_o` is 1. Both lines change only on bit ticks, apart from the rise of `tx_cmd_o` on start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Transmit start request, one cycle |
| bit_en_i | input | 1 | Bit-time enable, one cycle per bit |
| gap_cmd_en_i | input | DLY_W | Wait from command rise to enable rise |
| gap_en_data_i | input | DLY_W | Wait from enable rise to first data bit |
| gap_data_en_i | input | DLY_W | Wait from data end to enable fall |
| gap_en_cmd_i | input | DLY_W | Wait from enable fall to command fall |
| fifo_data_i | input | DATA_W | Show-ahead FIFO head byte |
| fifo_last_i | input | 1 | Head byte is the last of the frame |
| fifo_pop_o | output | 1 | Removes the head byte this edge |
| tx_cmd_o | output | 1 | Transmit command line to the PHY |
| phy_en_o | output | 1 | PHY enable line |
| sdata_o | output | 1 | Serial transmit data |
| busy_o | output | 1 | Sequence in progress |

## Verification
The assertions assume the FIFO already holds the whole frame when the sequence starts, so `fifo_data_i` and `fifo_last_i` are valid at every pop. They also assume that `start_i` and `bit_en_i` change only between clock edges. The bench loads a complete frame of 1 to 6 random bytes into its FIFO model before each start, with the last flag set only on the final byte. It drives every input on the falling edge. The bit-enable density is random per run, and some runs hold it at 1 continuously.

// File: rtl/txseq_pkg.sv
package txseq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_SETUP,
    ST_SHIFT,
    ST_TAIL,
    ST_DROP
  } seq_state_t;

  localparam int unsigned GAP_N = 4;
  localparam int unsigned GAP_SEL_W = $clog2(GAP_N);

  localparam logic [GAP_SEL_W-1:0] GAP_LEAD  = 2'd0;
  localparam logic [GAP_SEL_W-1:0] GAP_SETUP = 2'd1;
  localparam logic [GAP_SEL_W-1:0] GAP_TAIL  = 2'd2;
  localparam logic [GAP_SEL_W-1:0] GAP_DROP  = 2'd3;
endpackage

// File: rtl/txseq_gap_timer.sv
module txseq_gap_timer #(
  parameter int unsigned DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [DLY_W-1:0] limit_i,
  output logic             done_o
);
  logic [DLY_W-1:0] cnt_q;

  assign done_o = run_i && tick_i && (cnt_q == limit_i);

  always_ff @(posedge clk) begin
    if (rst || !run_i || done_o) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/txseq_serializer.sv
module txseq_serializer #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic              shift_i,
  input  logic              clear_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              last_i,
  output logic              sdata_o,
  output logic              bit_last_o,
  output logic              frame_last_o
);
  localparam int unsigned IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(DATA_W - 1);

  logic [DATA_W-1:0] rest_q;
  logic [IDX_W-1:0]  idx_q;
  logic              sdata_q;
  logic              last_q;

  assign sdata_o      = sdata_q;
  assign bit_last_o   = (idx_q == IDX_TOP);
  assign frame_last_o = last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rest_q  <= '0;
      idx_q   <= '0;
      sdata_q <= 1'b0;
      last_q  <= 1'b0;
    end else if (load_i) begin
      sdata_q <= byte_i[0];
      rest_q  <= byte_i >> 1;
      idx_q   <= '0;
      last_q  <= last_i;
    end else if (shift_i) begin
      sdata_q <= rest_q[0];
      rest_q  <= rest_q >> 1;
      idx_q   <= idx_q + 1'b1;
    end else if (clear_i) begin
      sdata_q <= 1'b0;
      rest_q  <= '0;
      idx_q   <= '0;
      last_q  <= 1'b0;
    end
  end
endmodule

// File: rtl/txseq_ctrl.sv
module txseq_ctrl
  import txseq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start_i,
  input  logic                 tick_i,
  input  logic                 gap_done_i,
  input  logic                 bit_last_i,
  input  logic                 frame_last_i,
  output logic [GAP_SEL_W-1:0] gap_sel_o,
  output logic                 gap_run_o,
  output logic                 ser_load_o,
  output logic                 ser_shift_o,
  output logic                 ser_clear_o,
  output logic                 tx_cmd_o,
  output logic                 phy_en_o,
  output logic                 busy_o
);
  seq_state_t state_q;
  logic       cmd_q, en_q, busy_q;
  logic       byte_end;

  assign tx_cmd_o = cmd_q;
  assign phy_en_o = en_q;
  assign busy_o   = busy_q;

  assign byte_end = (state_q == ST_SHIFT) && tick_i && bit_last_i;

  always_comb begin
    gap_sel_o = GAP_LEAD;
    gap_run_o = 1'b1;
    unique case (state_q)
      ST_LEAD:  gap_sel_o = GAP_LEAD;
      ST_SETUP: gap_sel_o = GAP_SETUP;
      ST_TAIL:  gap_sel_o = GAP_TAIL;
      ST_DROP:  gap_sel_o = GAP_DROP;
      default:  gap_run_o = 1'b0;
    endcase
  end

  assign ser_load_o  = ((state_q == ST_SETUP) && gap_done_i) || (byte_end && !frame_last_i);
  assign ser_shift_o = (state_q == ST_SHIFT) && tick_i && !bit_last_i;
  assign ser_clear_o = byte_end && frame_last_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cmd_q   <= 1'b0;
      en_q    <= 1'b0;
      busy_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_LEAD;
          cmd_q   <= 1'b1;
          busy_q  <= 1'b1;
        end
        ST_LEAD: if (gap_done_i) begin
          state_q <= ST_SETUP;
          en_q    <= 1'b1;
        end
        ST_SETUP: if (gap_done_i) state_q <= ST_SHIFT;
        ST_SHIFT: if (ser_clear_o) state_q <= ST_TAIL;
        ST_TAIL: if (gap_done_i) begin
          state_q <= ST_DROP;
          en_q    <= 1'b0;
        end
        ST_DROP: if (gap_done_i) begin
          state_q <= ST_IDLE;
          cmd_q   <= 1'b0;
          busy_q  <= 1'b0;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/txphy_seq.sv
module txphy_seq
  import txseq_pkg::*;
#(
  parameter int unsigned DLY_W  = 8,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              bit_en_i,
  input  logic [DLY_W-1:0]  gap_cmd_en_i,
  input  logic [DLY_W-1:0]  gap_en_data_i,
  input  logic [DLY_W-1:0]  gap_data_en_i,
  input  logic [DLY_W-1:0]  gap_en_cmd_i,
  input  logic [DATA_W-1:0] fifo_data_i,
  input  logic              fifo_last_i,
  output logic              fifo_pop_o,
  output logic              tx_cmd_o,
  output logic              phy_en_o,
  output logic              sdata_o,
  output logic              busy_o
);
  logic [DLY_W-1:0]     gap_tab [GAP_N];
  logic [GAP_SEL_W-1:0] gap_sel;
  logic                 gap_run, gap_done;
  logic                 ser_load, ser_shift, ser_clear;
  logic                 bit_last, frame_last;

  assign gap_tab[GAP_LEAD]  = gap_cmd_en_i;
  assign gap_tab[GAP_SETUP] = gap_en_data_i;
  assign gap_tab[GAP_TAIL]  = gap_data_en_i;
  assign gap_tab[GAP_DROP]  = gap_en_cmd_i;

  assign fifo_pop_o = ser_load;

  txseq_gap_timer #(.DLY_W(DLY_W)) timer_i (
    .clk     (clk),
    .rst     (rst),
    .run_i   (gap_run),
    .tick_i  (bit_en_i),
    .limit_i (gap_tab[gap_sel]),
    .done_o  (gap_done)
  );

  txseq_serializer #(.DATA_W(DATA_W)) ser_i (
    .clk          (clk),
    .rst          (rst),
    .load_i       (ser_load),
    .shift_i      (ser_shift),
    .clear_i      (ser_clear),
    .byte_i       (fifo_data_i),
    .last_i       (fifo_last_i),
    .sdata_o      (sdata_o),
    .bit_last_o   (bit_last),
    .frame_last_o (frame_last)
  );

  txseq_ctrl ctrl_i (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .tick_i       (bit_en_i),
    .gap_done_i   (gap_done),
    .bit_last_i   (bit_last),
    .frame_last_i (frame_last),
    .gap_sel_o    (gap_sel),
    .gap_run_o    (gap_run),
    .ser_load_o   (ser_load),
    .ser_shift_o  (ser_shift),
    .ser_clear_o  (ser_clear),
    .tx_cmd_o     (tx_cmd_o),
    .phy_en_o     (phy_en_o),
    .busy_o       (busy_o)
  );
endmodule

// File: rtl/txphy_seq_chk.sv
module txphy_seq_chk (
  input logic clk,
  input logic rst,
  input logic start_i,
  input logic bit_en_i,
  input logic fifo_pop_o,
  input logic tx_cmd_o,
  input logic phy_en_o,
  input logic sdata_o,
  input logic busy_o
);
  assert_start_R1: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o) |=> (tx_cmd_o && busy_o));

  assert_pop_tick_R3: assert property (@(posedge clk) disable iff (rst)
    fifo_pop_o |-> (bit_en_i && phy_en_o));

  assert_idle_data_R5: assert property (@(posedge clk) disable iff (rst)
    !phy_en_o |-> !sdata_o);

  assert_busy_cmd_R7: assert property (@(posedge clk) disable iff (rst)
    busy_o == tx_cmd_o);

  assert_ignore_start_R8: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !phy_en_o && start_i && !bit_en_i) |=> tx_cmd_o);

  assert_nest_R10: assert property (@(posedge clk) disable iff (rst)
    phy_en_o |-> tx_cmd_o);

  assert_en_on_tick_R10: assert property (@(posedge clk) disable iff (rst)
    !bit_en_i |=> $stable(phy_en_o));

  assert_cmd_fall_tick_R10: assert property (@(posedge clk) disable iff (rst)
    (tx_cmd_o && !bit_en_i) |=> tx_cmd_o);
endmodule

bind txphy_seq txphy_seq_chk chk_i (
  .clk        (clk),
  .rst        (rst),
  .start_i    (start_i),
  .bit_en_i   (bit_en_i),
  .fifo_pop_o (fifo_pop_o),
  .tx_cmd_o   (tx_cmd_o),
  .phy_en_o   (phy_en_o),
  .sdata_o    (sdata_o),
  .busy_o     (busy_o)
);

// File: tb/txphy_seq_tb_top.sv
module txphy_seq_tb_top;
  localparam int DLY_W  = 8;
  localparam int DATA_W = 8;
  localparam int MAXLEN = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic bit_en = 1'b0;
  logic [DLY_W-1:0] g0 = '0, g1 = '0, g2 = '0, g3 = '0;
  logic [DATA_W-1:0] frame [MAXLEN];
  int   flen = 1;
  int   ptr = 0;
  int   en_pct = 100;
  logic [DATA_W-1:0] fdata;
  logic flast, pop, cmd, en, sd, busy;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  assign fdata = (ptr < flen) ? frame[ptr] : '0;
  assign flast = (ptr == flen - 1);

  txphy_seq #(.DLY_W(DLY_W), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst(rst), .start_i(start), .bit_en_i(bit_en),
    .gap_cmd_en_i(g0), .gap_en_data_i(g1), .gap_data_en_i(g2), .gap_en_cmd_i(g3),
    .fifo_data_i(fdata), .fifo_last_i(flast), .fifo_pop_o(pop),
    .tx_cmd_o(cmd), .phy_en_o(en), .sdata_o(sd), .busy_o(busy)
  );

  always @(posedge clk) if (pop) ptr <= ptr + 1;

  always @(negedge clk) bit_en <= (($urandom % 100) < en_pct);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int bit_of(input int k);
    return int'(frame[k / DATA_W][k % DATA_W]);
  endfunction

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      finish_run();
    end
  end

  task automatic run_frame(input int d0, input int d1, input int d2, input int d3,
                           input int len, input int pct, input bit poke);
    int phase, ticks, bits, guard;
    bit t, poked;
    g0 = DLY_W'(d0); g1 = DLY_W'(d1); g2 = DLY_W'(d2); g3 = DLY_W'(d3);
    flen = len;
    en_pct = pct;
    for (int i = 0; i < MAXLEN; i++) frame[i] = DATA_W'($urandom);
    @(negedge clk);
    ptr = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(cmd && busy, "R1 start raises command", int'({cmd, busy}), 3);
    phase = 0; ticks = 0; bits = 0; guard = 0; poked = 1'b0;
    while (phase < 4 && guard < 20000) begin
      @(negedge clk);
      start = 1'b0;
      guard++;
      t = bit_en;
      if (t) ticks++;
      case (phase)
        0: begin
          if (en) begin
            check(ticks == d0 + 1, "R2 enable delay", ticks, d0 + 1);
            phase = 1; ticks = 0;
          end else if (ticks > d0 + 1) begin
            check(0, "R2 enable late", ticks, d0 + 1); guard = 20000;
          end
        end
        1: begin
          if (ticks == d1 + 1) begin
            check(sd == bit_of(0) && ptr == 1, "R3 first bit and pop", int'(sd), bit_of(0));
            phase = 2; bits = 1;
          end else if (sd !== 1'b0 || ptr != 0) begin
            check(0, "R5 data before start", int'(sd), 0); guard = 20000;
          end
        end
        2: begin
          if (poke && !poked) begin
            start = 1'b1; poked = 1'b1;
          end
          if (t) begin
            if (bits < len * DATA_W) begin
              if (sd != bit_of(bits)) check(0, "R4 serial bit", int'(sd), bit_of(bits));
              bits++;
            end else begin
              check(sd == 1'b0 && en, "R5 data idles after last bit", int'(sd), 0);
              check(ptr == len, "R3 pop count", ptr, len);
              phase = 3; ticks = 0;
            end
          end
        end
        3: begin
          if (!en) begin
            check(ticks == d2 + 1 && cmd, "R6 enable release delay", ticks, d2 + 1);
            phase = 4; ticks = 0;
          end else if (ticks > d2 + 1) begin
            check(0, "R6 enable release late", ticks, d2 + 1); guard = 20000;
          end
        end
        default: ;
      endcase
      if (phase == 4) begin
        phase = 5;
      end
    end
    check(guard < 20000, "R4 sequence progress", guard, 0);
    ticks = 0;
    guard = 0;
    while (cmd && guard < 20000) begin
      @(negedge clk);
      guard++;
      if (bit_en) ticks++;
      if (sd !== 1'b0) check(0, "R5 data during drop", int'(sd), 0);
    end
    check(ticks == d3 + 1 && !busy, "R7 command release delay", ticks, d3 + 1);
    if (poke) begin
      repeat (6) @(negedge clk);
      check(!cmd && !busy, "R8 start during busy ignored", int'(cmd), 0);
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check({cmd, en, sd, busy, pop} == 5'b0, "R9 outputs during reset", int'({cmd, en, sd, busy, pop}), 0);
    rst = 1'b0;
    @(negedge clk);
    check({cmd, en, sd, busy, pop} == 5'b0, "R9 outputs after reset", int'({cmd, en, sd, busy, pop}), 0);
    // directed corners
    run_frame(0, 0, 0, 0, 1, 100, 1'b0);
    run_frame(0, 0, 0, 0, 2, 30, 1'b1);
    run_frame(255, 255, 255, 255, 1, 100, 1'b0);
    run_frame(3, 0, 7, 1, 3, 60, 1'b1);
    // random runs
    for (int r = 0; r < 30; r++) begin
      run_frame(int'($urandom % 16), int'($urandom % 16), int'($urandom % 16),
                int'($urandom % 16), 1 + int'($urandom % 6),
                (r % 4 == 0) ? 100 : 20 + int'($urandom % 70), (r % 3) == 0);
    end
    finish_run();
  end
endmodule